// File: doc/BRIEF.md
# Tagged Byte FIFO with Run-Length Expansion

This block is the byte queue at the centre of an extended-capabilities parallel port. Each stored entry is nine bits: a data byte plus a tag bit. The host can fill the queue through two write ports. The data port always stores the tag set. The test port stores a tag value that the caller chooses. The host drains the queue through two read strobes.

A read through the data port expands run-length-encoded input. A count entry is one whose tag is clear and whose bit 7 is clear. When such an entry reaches the head, it is consumed silently. The byte behind it is then handed out one more time than the count says, and only after that is it removed from the queue. A read through the test port returns the stored bytes as they are, with no expansion. A read while the queue is empty never fails: the previous byte is presented again and the flags do not move.

A small read-only configuration view reports that the port uses 8-bit words and pulsed interrupts. It also reports whether a byte is held outside the queue for transmission. The view is visible only when the port mode input is 111.

Top module: `ecp_rle_fifo`

## Requirements
- R1: A write on `ecp_wr` stores `wr_data` with the tag set to 1. A write on `test_wr` stores `wr_data` with tag `test_wr_tag`. If both strobes are high, the data port's tag rule applies.
- R2: A write is stored only while `fifo_full` is low. A write made while `fifo_full` is high is discarded and never read back. `fifo_full` is high when DEPTH entries are held, and `fifo_empty` is high when none are held.
- R3: An `ecp_rd` read may find at the head an entry with tag 0 and data bit 7 equal to 0. That entry is a count N (bits 6:0). It is consumed and never returned. The next entry's byte is returned on N+1 consecutive reads, and only then is that entry removed.
- R4: A count may reach the head with no byte behind it. The count is still consumed, and reads return the last delivered byte. When the data byte is written later, it is returned N+1 times.
- R5: A read of either kind while `fifo_empty` is high returns the last delivered byte again. It leaves `fifo_empty` high and removes nothing.
- R6: A `test_rd` read returns the head byte unchanged, even when that byte is a count, and removes it.
- R7: `rd_data` is registered. It changes on the clock edge that samples the read strobe. After reset, `rd_data` is 0, `fifo_empty` is 1 and `fifo_full` is 0.
- R8: When `port_mode` is 3'b111, `cfg_data` reads as follows: bit 7 is 1 (pulsed interrupts), bits 6:4 are 3'b001 (8-bit word), bit 3 is 0, bit 2 is `xmit_hold`, and bits 1:0 are 0. In every other mode, `cfg_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecp_wr | input | 1 | Write strobe for the data port (tag set) |
| test_wr | input | 1 | Write strobe for the test port |
| test_wr_tag | input | 1 | Tag value stored by a test-port write |
| wr_data | input | 8 | Write byte |
| ecp_rd | input | 1 | Read strobe for the data port, with expansion |
| test_rd | input | 1 | Read strobe for the test port, raw |
| rd_data | output | 8 | Registered read byte |
| fifo_full | output | 1 | Queue holds DEPTH entries |
| fifo_empty | output | 1 | Queue holds no entries |
| port_mode | input | 3 | Port mode; 3'b111 exposes the configuration view |
| xmit_hold | input | 1 | A byte is held for transmission outside the queue |
| cfg_data | output | 8 | Configuration view |

## Verification
The assertions assume that reads come from one port at a time within a run. Once a count has been consumed, the rest of that run is drained through `ecp_rd` only. The assertions also assume that reset is applied before any strobe. The stimulus drives every strobe for exactly one cycle between falling edges. It drains each expansion run completely through the data port before it uses the test port. It sweeps count values from 0 up to the 7-bit maximum, so that no stray test read lands in the middle of an expansion.

// File: rtl/ecp_fifo_pkg.sv
package ecp_fifo_pkg;

    localparam int BYTE_W  = 8;
    localparam int COUNT_W = 7;

    typedef struct packed {
        logic              tag;
        logic [BYTE_W-1:0] data;
    } fifo_entry_t;

    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_ECP  = 2'd1,
        RD_TEST = 2'd2
    } rd_kind_e;

    localparam logic [2:0] CFG_MODE      = 3'b111;
    localparam logic [2:0] CFG_WORD_8BIT = 3'b001;
    localparam logic       CFG_PULSED    = 1'b1;

    function automatic logic is_run_count(input fifo_entry_t e);
        return (e.tag == 1'b0) && (e.data[BYTE_W-1] == 1'b0);
    endfunction

    function automatic logic [BYTE_W-1:0] cfg_word(input logic hold);
        return {CFG_PULSED, CFG_WORD_8BIT, 1'b0, hold, 2'b00};
    endfunction

endpackage

// File: rtl/ecp_fifo_store.sv
module ecp_fifo_store
    import ecp_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push,
    input  fifo_entry_t push_entry,
    input  logic [1:0]  pop_n,
    output fifo_entry_t head,
    output fifo_entry_t nxt,
    output logic [AW:0] level,
    output logic        full,
    output logic        empty
);

    fifo_entry_t mem [DEPTH];
    logic [AW:0] wptr, rptr;
    logic [AW:0] rptr_next1;
    logic        push_ok;

    assign level      = wptr - rptr;
    assign full       = (level == (AW+1)'(DEPTH));
    assign empty      = (level == '0);
    assign push_ok    = push && !full;
    assign rptr_next1 = rptr + 1'b1;
    assign head       = mem[rptr[AW-1:0]];
    assign nxt        = mem[rptr_next1[AW-1:0]];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wptr[AW-1:0]] <= push_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push_ok) begin
                wptr <= wptr + 1'b1;
            end
            rptr <= rptr + (AW+1)'(pop_n);
        end
    end

    // R2: a write into a full queue leaves the write pointer where it was
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> $stable(wptr));

    // R2: occupancy never exceeds the depth
    a_r2_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= (AW+1)'(DEPTH));

endmodule

// File: rtl/ecp_rle_reader.sv
module ecp_rle_reader
    import ecp_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  rd_kind_e          rd_kind,
    input  fifo_entry_t       head,
    input  fifo_entry_t       nxt,
    input  logic [AW:0]       level,
    input  logic              empty,
    output logic [1:0]        pop_n,
    output logic [BYTE_W-1:0] rd_data
);

    logic               run_active, run_active_d;
    logic [COUNT_W-1:0] run_cnt, run_cnt_d;
    logic [BYTE_W-1:0]  rd_data_d;
    logic [COUNT_W-1:0] head_cnt;

    assign head_cnt = head.data[COUNT_W-1:0];

    always_comb begin
        pop_n        = 2'd0;
        rd_data_d    = rd_data;
        run_active_d = run_active;
        run_cnt_d    = run_cnt;
        unique case (rd_kind)
            RD_ECP: begin
                if (!empty) begin
                    if (run_active) begin
                        rd_data_d = head.data;
                        if (run_cnt == '0) begin
                            pop_n        = 2'd1;
                            run_active_d = 1'b0;
                        end else begin
                            run_cnt_d = run_cnt - 1'b1;
                        end
                    end else if (is_run_count(head)) begin
                        pop_n        = 2'd1;
                        run_active_d = 1'b1;
                        run_cnt_d    = head_cnt;
                        if (level > (AW+1)'(1)) begin
                            rd_data_d = nxt.data;
                            if (head_cnt == '0) begin
                                pop_n        = 2'd2;
                                run_active_d = 1'b0;
                            end else begin
                                run_cnt_d = head_cnt - 1'b1;
                            end
                        end
                    end else begin
                        rd_data_d = head.data;
                        pop_n     = 2'd1;
                    end
                end
            end
            RD_TEST: begin
                if (!empty) begin
                    rd_data_d = head.data;
                    pop_n     = 2'd1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_active <= 1'b0;
            run_cnt    <= '0;
            rd_data    <= '0;
        end else begin
            run_active <= run_active_d;
            run_cnt    <= run_cnt_d;
            rd_data    <= rd_data_d;
        end
    end

    // R5: an underrun read repeats the previous byte
    a_r5_underrun_repeats: assert property (@(posedge clk) disable iff (rst)
        (rd_kind != RD_NONE && empty) |=> $stable(rd_data));

    // R3: never remove more entries than are held
    a_r3_pop_bound: assert property (@(posedge clk) disable iff (rst)
        (AW+1)'(pop_n) <= level);

    // R3: while expanding a run, a repeat read keeps the head in place
    a_r3_run_holds: assert property (@(posedge clk) disable iff (rst)
        (rd_kind == RD_ECP && run_active && !empty && run_cnt != '0)
            |=> (run_active && run_cnt == $past(run_cnt) - 1'b1));

endmodule

// File: rtl/ecp_cfg_view.sv
module ecp_cfg_view
    import ecp_fifo_pkg::*;
(
    input  logic [2:0]        port_mode,
    input  logic              xmit_hold,
    output logic [BYTE_W-1:0] cfg_data
);

    always_comb begin
        cfg_data = '0;
        if (port_mode == CFG_MODE) begin
            cfg_data = cfg_word(xmit_hold);
        end
    end

endmodule

// File: rtl/ecp_rle_fifo.sv
module ecp_rle_fifo
    import ecp_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ecp_wr,
    input  logic       test_wr,
    input  logic       test_wr_tag,
    input  logic [7:0] wr_data,
    input  logic       ecp_rd,
    input  logic       test_rd,
    output logic [7:0] rd_data,
    output logic       fifo_full,
    output logic       fifo_empty,
    input  logic [2:0] port_mode,
    input  logic       xmit_hold,
    output logic [7:0] cfg_data
);

    fifo_entry_t push_entry, head, nxt;
    logic        push;
    logic [1:0]  pop_n;
    logic [AW:0] level;
    rd_kind_e    rd_kind;

    assign push           = ecp_wr || test_wr;
    assign push_entry.tag = ecp_wr ? 1'b1 : test_wr_tag;
    assign push_entry.data = wr_data;

    always_comb begin
        if (ecp_rd)       rd_kind = RD_ECP;
        else if (test_rd) rd_kind = RD_TEST;
        else              rd_kind = RD_NONE;
    end

    ecp_fifo_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_entry (push_entry),
        .pop_n      (pop_n),
        .head       (head),
        .nxt        (nxt),
        .level      (level),
        .full       (fifo_full),
        .empty      (fifo_empty)
    );

    ecp_rle_reader #(.DEPTH(DEPTH)) u_reader (
        .clk     (clk),
        .rst     (rst),
        .rd_kind (rd_kind),
        .head    (head),
        .nxt     (nxt),
        .level   (level),
        .empty   (fifo_empty),
        .pop_n   (pop_n),
        .rd_data (rd_data)
    );

    ecp_cfg_view u_cfg (
        .port_mode (port_mode),
        .xmit_hold (xmit_hold),
        .cfg_data  (cfg_data)
    );

    // R5: an underrun read with no write leaves the queue empty
    a_r5_empty_kept: assert property (@(posedge clk) disable iff (rst)
        ((ecp_rd || test_rd) && fifo_empty && !push) |=> fifo_empty);

    // R2: full and empty are never raised together
    a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(fifo_full && fifo_empty));

endmodule

// File: tb/ecp_rle_fifo_tb.sv
module ecp_rle_fifo_tb;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ecp_wr = 1'b0, test_wr = 1'b0, test_wr_tag = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ecp_rd = 1'b0, test_rd = 1'b0;
    logic [7:0] rd_data;
    logic       fifo_full, fifo_empty;
    logic [2:0] port_mode = 3'b000;
    logic       xmit_hold = 1'b0;
    logic [7:0] cfg_data;

    int n_checks = 0;
    int n_fails  = 0;

    always #5ns clk = ~clk;

    ecp_rle_fifo #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .ecp_wr(ecp_wr), .test_wr(test_wr),
        .test_wr_tag(test_wr_tag), .wr_data(wr_data), .ecp_rd(ecp_rd),
        .test_rd(test_rd), .rd_data(rd_data), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty), .port_mode(port_mode), .xmit_hold(xmit_hold),
        .cfg_data(cfg_data)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put_ecp(input logic [7:0] d);
        @(negedge clk); ecp_wr = 1'b1; wr_data = d;
        @(negedge clk); ecp_wr = 1'b0;
    endtask

    task automatic put_test(input logic tag, input logic [7:0] d);
        @(negedge clk); test_wr = 1'b1; test_wr_tag = tag; wr_data = d;
        @(negedge clk); test_wr = 1'b0; test_wr_tag = 1'b0;
    endtask

    task automatic get_ecp();
        @(negedge clk); ecp_rd = 1'b1;
        @(negedge clk); ecp_rd = 1'b0;
    endtask

    task automatic get_test();
        @(negedge clk); test_rd = 1'b1;
        @(negedge clk); test_rd = 1'b0;
    endtask

    function automatic logic [7:0] fill_byte(input int i);
        return 8'((i * 7 + 3) & 8'h7f);
    endfunction

    initial begin
        int counts [5] = '{0, 1, 2, 5, 127};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7: reset state
        check("R7 reset rd_data", rd_data, 0);
        check("R7 reset empty", fifo_empty, 1);
        check("R7 reset full", fifo_full, 0);

        // R2 / R1: fill to depth; data-port bytes with bit 7 low carry tag 1, so no expansion
        for (int i = 0; i < DEPTH; i++) begin
            put_ecp(fill_byte(i));
            if (i == DEPTH - 2) check("R2 not full at depth-1", fifo_full, 0);
        end
        check("R2 full at depth", fifo_full, 1);
        put_ecp(8'hEE);
        check("R2 still full after dropped write", fifo_full, 1);
        for (int i = 0; i < DEPTH; i++) begin
            get_ecp();
            check("R1 R2 drain order", rd_data, fill_byte(i));
        end
        check("R2 empty after drain", fifo_empty, 1);

        // R5: underrun on data port
        get_ecp();
        check("R5 underrun repeats last", rd_data, fill_byte(DEPTH - 1));
        check("R5 underrun keeps empty", fifo_empty, 1);

        // R7: read data appears on the edge that samples the strobe
        put_ecp(8'h11);
        @(negedge clk); ecp_rd = 1'b1;
        #1ns check("R7 not before edge", rd_data, fill_byte(DEPTH - 1));
        @(negedge clk); ecp_rd = 1'b0;
        check("R7 after edge", rd_data, 8'h11);

        // R3: expansion sweep across count values
        foreach (counts[k]) begin
            logic [7:0] d;
            d = 8'h80 | 8'(k * 13);
            put_test(1'b0, 8'(counts[k]));
            put_ecp(d);
            put_ecp(8'h5A);
            for (int r = 0; r <= counts[k]; r++) begin
                get_ecp();
                check("R3 repeated byte", rd_data, d);
            end
            check("R3 marker still queued", fifo_empty, 0);
            get_ecp();
            check("R3 marker after run", rd_data, 8'h5A);
            check("R3 empty after run", fifo_empty, 1);
        end

        // R3 / R1: bit 7 set with tag 0, and tag 1 with bit 7 clear, are plain data
        put_test(1'b0, 8'h85);
        put_ecp(8'h05);
        get_ecp();
        check("R3 tag0 bit7 set is data", rd_data, 8'h85);
        get_ecp();
        check("R1 tagged byte is data", rd_data, 8'h05);
        check("R3 empty after plain bytes", fifo_empty, 1);

        // R4: count with no following byte
        put_test(1'b0, 8'd2);
        get_ecp();
        check("R4 lone count returns last", rd_data, 8'h05);
        check("R4 count consumed", fifo_empty, 1);
        get_ecp();
        check("R4 waiting read returns last", rd_data, 8'h05);
        put_ecp(8'h3C);
        for (int r = 0; r < 3; r++) begin
            get_ecp();
            check("R4 late byte repeated", rd_data, 8'h3C);
        end
        check("R4 empty after late run", fifo_empty, 1);

        // R6: test port reads are raw
        put_test(1'b0, 8'h03);
        put_ecp(8'h77);
        get_test();
        check("R6 raw count byte", rd_data, 8'h03);
        get_test();
        check("R6 raw data byte", rd_data, 8'h77);
        check("R6 empty", fifo_empty, 1);
        get_test();
        check("R5 R6 test underrun", rd_data, 8'h77);
        check("R5 R6 test underrun empty", fifo_empty, 1);

        // R8: configuration view
        for (int m = 0; m < 8; m++) begin
            for (int h = 0; h < 2; h++) begin
                port_mode = 3'(m); xmit_hold = 1'(h);
                #1ns;
                check("R8 cfg view", cfg_data, (m == 7) ? (8'h90 | (h << 2)) : 0);
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #1ms;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule